// File: doc/BRIEF.md
# Packet Timestamp Latch Bank

This block holds hardware timestamps for event packets until software collects them. It captures a free-running 64-bit nanosecond time value when a receive or transmit event strobe arrives. The packet parser upstream has already qualified the strobes as event messages. Receive captures go into a small pool of slots. Each capture returns a slot index, which the receive path passes on with the packet. Software then uses that index to read the matching slot.

A slot stays locked after capture, and only software reading its upper word unlocks it. When every slot is locked, new receive events get no timestamp, and this continues until software frees a slot. The transmit side has a single latch. That latch raises a level interrupt, when enabled, and records a sticky overflow if a second transmit event arrives before the first value is collected.

All stored values reach software through one 32-bit read port. Reads take effect on the clock edge. A read of a releasing address returns the held value in the same cycle and frees the latch at that edge.

Top module: `ts_latch_bank`

## Requirements
- R1: After reset every receive slot and the transmit latch are empty, `rx_status` is 0, `irq` is 0, and the status word (address 0) reads 0.
- R2: A receive event takes the lowest-numbered free slot. `rx_slot_vld` and `rx_slot` report that index combinationally in the cycle of the strobe. The slot then holds the `time_now` value present at that clock edge: the low half at address 4+2i and the high half at address 5+2i.
- R3: Bit i of `rx_status`, and bit i of the status word, is 1 exactly while slot i holds an uncollected timestamp.
- R4: A read of address 5+2i (slot i upper word) frees slot i at that edge. A read of the lower word at 4+2i leaves the slot occupied.
- R5: A receive event that finds all slots occupied gives `rx_slot_vld`=0 and leaves every slot's stored value and status unchanged.
- R6: When a read frees slot i in the same cycle as a receive event, and slot i is the lowest free slot after that release, the event is granted slot i and slot i stores the new time.
- R7: A transmit event latches `time_now` into the transmit latch (low half at address 1, high half at address 2) and sets status bit 8. A read of address 2 frees the latch. A transmit event that arrives while the latch is occupied and not being freed is dropped: the stored value is kept and status bit 9 is set. Bit 9 stays set until the status word is read, and a read of address 0 clears it at that edge.
- R8: `irq` equals 1 while the transmit latch is occupied and `tx_irq_en` is 1. It stays high until address 2 is read. With `tx_irq_en`=0, a transmit capture leaves `irq` at 0.
- R9: A stored timestamp stays unchanged while `time_now` moves on. Address 3, and addresses above the last slot, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current clock value in nanoseconds |
| rx_evt | input | 1 | Qualified receive event strobe |
| tx_evt | input | 1 | Qualified transmit event strobe |
| tx_irq_en | input | 1 | Enables the transmit capture interrupt |
| rd_en | input | 1 | Register read strobe; side effects apply at the clock edge |
| rd_addr | input | 4 | Register word address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| rx_slot | output | 2 | Slot index granted to the current receive event |
| rx_slot_vld | output | 1 | Receive event received a slot |
| rx_status | output | 4 | Occupied flag per receive slot |
| irq | output | 1 | Level interrupt for a pending transmit timestamp |

## Verification
Two functions can fall in the same cycle. The first pair is a software read of a slot's upper word, which frees the slot, and a new receive capture that wants a slot. The bench fills every slot, then drives the release read of slot 2 and a receive strobe on the same falling edge. It judges the result by the granted index reported in that cycle, and by the new time read back from slot 2 afterwards, rather than the old value. A second test shows that a transmit event arriving while the latch is full is dropped. The bench checks this through the preserved low word and the sticky overflow bit, which must then clear after a status read.

// File: rtl/ts_pkg.sv
package ts_pkg;
   // Word address map of the read port
   localparam int ADDR_STATUS = 0;
   localparam int ADDR_TX_LO  = 1;
   localparam int ADDR_TX_HI  = 2;
   localparam int ADDR_RX_BASE = 4;

   // Status word bit positions
   localparam int STAT_TX_FULL = 8;
   localparam int STAT_TX_OVF  = 9;
   localparam int MAX_RX_SLOTS = 8;

   function automatic int rx_lo_addr(input int slot);
      return ADDR_RX_BASE + 2 * slot;
   endfunction

   function automatic int rx_hi_addr(input int slot);
      return ADDR_RX_BASE + 2 * slot + 1;
   endfunction
endpackage

// File: rtl/ts_stamp_latch.sv
module ts_stamp_latch #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              rel,
   input  logic [TIME_W-1:0] time_in,
   output logic [TIME_W-1:0] q,
   output logic              full
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q    <= '0;
         full <= 1'b0;
      end else if (cap) begin
         q    <= time_in;
         full <= 1'b1;
      end else if (rel) begin
         full <= 1'b0;
      end
   end

   // R5/R6: a capture is only ever steered into a latch that is free this cycle
   p_cap_only_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> (!full || rel));
   // R4: a release without a capture empties the latch
   p_release_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rel && !cap) |=> !full);
   // R9: a held value does not move while no capture arrives
   p_hold_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !cap) |=> $stable(q));
endmodule

// File: rtl/ts_slot_alloc.sv
module ts_slot_alloc #(
   parameter int NUM_SLOTS = 4,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic [NUM_SLOTS-1:0] free,
   output logic [NUM_SLOTS-1:0] grant,
   output logic [SLOT_W-1:0]    idx,
   output logic                 vld
);
   logic [NUM_SLOTS:0] lower_free;

   assign lower_free[0] = 1'b0;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chain
      assign grant[i]        = req & free[i] & ~lower_free[i];
      assign lower_free[i+1] = lower_free[i] | free[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (grant[i]) idx = idx | SLOT_W'(i);
      end
   end

   assign vld = |grant;

   // R2: never more than one slot granted
   p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R5: a request with any free slot is always served
   p_served_when_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && |free) |-> vld);
endmodule

// File: rtl/ts_latch_bank.sv
module ts_latch_bank #(
   parameter int TIME_W    = 64,
   parameter int REG_W     = 32,
   parameter int NUM_SLOTS = 4,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int ADDR_W = $clog2(ts_pkg::ADDR_RX_BASE + 2 * NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_now,
   input  logic              rx_evt,
   input  logic              tx_evt,
   input  logic              tx_irq_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic [SLOT_W-1:0] rx_slot,
   output logic              rx_slot_vld,
   output logic [NUM_SLOTS-1:0] rx_status,
   output logic              irq
);
   import ts_pkg::*;

   localparam int RX_END = ADDR_RX_BASE + 2 * NUM_SLOTS;

   if (TIME_W != 2 * REG_W) begin : g_bad_width
      $error("TIME_W must be twice REG_W");
   end
   if (NUM_SLOTS < 2 || NUM_SLOTS > MAX_RX_SLOTS || (NUM_SLOTS & (NUM_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two between 2 and 8");
   end
   if (REG_W <= STAT_TX_OVF) begin : g_bad_reg
      $error("REG_W too narrow for the status word");
   end

   // ---------------- release decode ----------------
   logic [NUM_SLOTS-1:0] rx_rel;
   logic                 tx_rel;
   logic                 stat_rd;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_rel
      assign rx_rel[i] = rd_en && (rd_addr == ADDR_W'(rx_hi_addr(i)));
   end
   assign tx_rel  = rd_en && (rd_addr == ADDR_W'(ADDR_TX_HI));
   assign stat_rd = rd_en && (rd_addr == ADDR_W'(ADDR_STATUS));

   // ---------------- receive slots ----------------
   logic [NUM_SLOTS-1:0] rx_full;
   logic [NUM_SLOTS-1:0] rx_free;
   logic [NUM_SLOTS-1:0] rx_grant;
   logic [TIME_W-1:0]    rx_q [NUM_SLOTS];

   assign rx_free = ~rx_full | rx_rel;

   ts_slot_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (rx_evt),
      .free  (rx_free),
      .grant (rx_grant),
      .idx   (rx_slot),
      .vld   (rx_slot_vld)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      ts_stamp_latch #(.TIME_W(TIME_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .cap     (rx_grant[i]),
         .rel     (rx_rel[i]),
         .time_in (time_now),
         .q       (rx_q[i]),
         .full    (rx_full[i])
      );
   end

   assign rx_status = rx_full;

   // ---------------- transmit latch ----------------
   logic              tx_full;
   logic              tx_take;
   logic              tx_ovf;
   logic [TIME_W-1:0] tx_q;

   assign tx_take = tx_evt && (!tx_full || tx_rel);

   ts_stamp_latch #(.TIME_W(TIME_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (tx_take),
      .rel     (tx_rel),
      .time_in (time_now),
      .q       (tx_q),
      .full    (tx_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 tx_ovf <= 1'b0;
      else if (tx_evt && !tx_take) tx_ovf <= 1'b1;
      else if (stat_rd)           tx_ovf <= 1'b0;
   end

   assign irq = tx_full & tx_irq_en;

   // ---------------- read mux ----------------
   logic [ADDR_W-1:0] rx_off;
   logic [SLOT_W-1:0] rx_sel;
   logic [REG_W-1:0]  status_word;

   always_comb begin
      status_word = '0;
      status_word[NUM_SLOTS-1:0] = rx_full;
      status_word[STAT_TX_FULL]  = tx_full;
      status_word[STAT_TX_OVF]   = tx_ovf;
   end

   assign rx_off = rd_addr - ADDR_W'(ADDR_RX_BASE);
   assign rx_sel = rx_off[SLOT_W:1];

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADDR_STATUS)) begin
         rd_data = status_word;
      end else if (rd_addr == ADDR_W'(ADDR_TX_LO)) begin
         rd_data = tx_q[REG_W-1:0];
      end else if (rd_addr == ADDR_W'(ADDR_TX_HI)) begin
         rd_data = tx_q[TIME_W-1:REG_W];
      end else if (rd_addr >= ADDR_W'(ADDR_RX_BASE) && 32'(rd_addr) < RX_END) begin
         rd_data = rx_off[0] ? rx_q[rx_sel][TIME_W-1:REG_W] : rx_q[rx_sel][REG_W-1:0];
      end
   end

   // R5: a full bank with no release in flight grants nothing
   p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && (&rx_full) && !(|rx_rel)) |-> !rx_slot_vld);
   // R7: the overflow flag holds until a status read
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !stat_rd) |=> tx_ovf);
   // R8: the interrupt holds until the transmit upper word is read
   p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !tx_rel && !tx_evt && $stable(tx_irq_en)) |=> (irq || !tx_irq_en));
   // R6: a same-cycle release of slot 0 lets a new event take slot 0
   p_reuse_slot0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_evt && rx_rel[0]) |-> (rx_slot_vld && rx_slot == '0));
endmodule

// File: tb/ts_latch_bank_test.sv
module ts_latch_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_now = '0;
   logic        rx_evt = 1'b0;
   logic        tx_evt = 1'b0;
   logic        tx_irq_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [1:0]  rx_slot;
   logic        rx_slot_vld;
   logic [3:0]  rx_status;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ts_latch_bank uut (
      .clk(clk), .rst_n(rst_n), .time_now(time_now), .rx_evt(rx_evt),
      .tx_evt(tx_evt), .tx_irq_en(tx_irq_en), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .rx_slot(rx_slot), .rx_slot_vld(rx_slot_vld),
      .rx_status(rx_status), .irq(irq)
   );

   function automatic logic [63:0] stamp(input int n);
      return {32'h1000_0000 + 32'(n) * 32'h0101, 32'hA000_0000 + 32'(n) * 32'h0011};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge with inputs idle
   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; rd_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0; rd_addr = '0;
   endtask

   task automatic rx(input logic [63:0] t, input bit exp_vld, input logic [1:0] exp_slot, input string req);
      time_now = t; rx_evt = 1'b1;
      #1;
      chk(rx_slot_vld == exp_vld, req, 64'(rx_slot_vld), 64'(exp_vld));
      if (exp_vld) chk(rx_slot == exp_slot, req, 64'(rx_slot), 64'(exp_slot));
      @(negedge clk);
      rx_evt = 1'b0;
      time_now = time_now + 64'd7;
   endtask

   task automatic expect_slot(input int s, input logic [63:0] t, input string req);
      logic [31:0] lo, hi;
      rd(4'(4 + 2 * s), lo);
      rd(4'(5 + 2 * s), hi);
      chk({hi, lo} == t, req, {hi, lo}, t);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk(rx_status == 4'h0, "R1 rx_status", 64'(rx_status), 0);
      chk(irq == 1'b0, "R1 irq", 64'(irq), 0);
      rd(4'd0, d);
      chk(d == 32'h0, "R1 status word", 64'(d), 0);
   endtask

   task automatic t_fill;
      logic [31:0] d;
      for (int i = 0; i < 4; i++) rx(stamp(i), 1'b1, 2'(i), "R2 lowest free slot");
      chk(rx_status == 4'hF, "R3 all occupied", 64'(rx_status), 64'hF);
      time_now = 64'hFFFF_0000_FFFF_0000;
      @(negedge clk);
      rd(4'd5, d);
      chk(d == stamp(0)[63:32], "R2 R9 slot0 high held", 64'(d), 64'(stamp(0)[63:32]));
      chk(rx_status == 4'hE, "R4 high read frees slot0", 64'(rx_status), 64'hE);
      rd(4'd6, d);
      chk(d == stamp(1)[31:0], "R2 slot1 low", 64'(d), 64'(stamp(1)[31:0]));
      chk(rx_status == 4'hE, "R4 low read keeps slot1", 64'(rx_status), 64'hE);
      rd(4'd0, d);
      chk(d[3:0] == 4'hE, "R3 status word bits", 64'(d[3:0]), 64'hE);
      rx(stamp(4), 1'b1, 2'd0, "R2 refill slot0");
   endtask

   task automatic t_full_drop;
      logic [31:0] d;
      rx(stamp(9), 1'b0, 2'd0, "R5 full bank drops");
      chk(rx_status == 4'hF, "R5 status unchanged", 64'(rx_status), 64'hF);
      rd(4'd10, d);
      chk(d == stamp(3)[31:0], "R5 slot3 unchanged", 64'(d), 64'(stamp(3)[31:0]));
      rd(4'd3, d);
      chk(d == 32'h0, "R9 unmapped address", 64'(d), 0);
      rd(4'd12, d);
      chk(d == 32'h0, "R9 address past slots", 64'(d), 0);
   endtask

   task automatic t_collide;
      logic [31:0] d;
      // slot 2 released and re-captured in one cycle
      rd_en = 1'b1; rd_addr = 4'd9;
      time_now = stamp(20); rx_evt = 1'b1;
      #1;
      d = rd_data;
      chk(d == stamp(2)[63:32], "R6 old value on release read", 64'(d), 64'(stamp(2)[63:32]));
      chk(rx_slot_vld && rx_slot == 2'd2, "R6 released slot granted", {rx_slot_vld, rx_slot}, 64'h6);
      @(negedge clk);
      rd_en = 1'b0; rx_evt = 1'b0;
      chk(rx_status == 4'hF, "R6 slot2 occupied again", 64'(rx_status), 64'hF);
      expect_slot(2, stamp(20), "R6 slot2 new time");
      chk(rx_status == 4'hB, "R4 slot2 freed", 64'(rx_status), 64'hB);
   endtask

   task automatic t_drain;
      for (int s = 0; s < 4; s++) begin
         logic [31:0] d;
         if (s != 2) rd(4'(5 + 2 * s), d);
      end
      chk(rx_status == 4'h0, "R4 all freed", 64'(rx_status), 0);
      rx(stamp(30), 1'b1, 2'd0, "R2 empty bank slot0");
      rx(stamp(31), 1'b1, 2'd1, "R2 next slot1");
      expect_slot(0, stamp(30), "R2 slot0 value");
      rx(stamp(32), 1'b1, 2'd0, "R2 lowest again after free");
   endtask

   task automatic t_tx;
      logic [31:0] d;
      tx_irq_en = 1'b1;
      time_now = stamp(40); tx_evt = 1'b1;
      @(negedge clk);
      tx_evt = 1'b0;
      chk(irq == 1'b1, "R8 irq after capture", 64'(irq), 1);
      time_now = stamp(41); tx_evt = 1'b1;
      @(negedge clk);
      tx_evt = 1'b0;
      rd(4'd0, d);
      chk(d[9:8] == 2'b11, "R7 busy and overflow", 64'(d[9:8]), 3);
      rd(4'd0, d);
      chk(d[9:8] == 2'b01, "R7 overflow cleared by status read", 64'(d[9:8]), 1);
      rd(4'd1, d);
      chk(d == stamp(40)[31:0], "R7 first value kept", 64'(d), 64'(stamp(40)[31:0]));
      chk(irq == 1'b1, "R8 irq holds after low read", 64'(irq), 1);
      rd(4'd2, d);
      chk(d == stamp(40)[63:32], "R7 high word", 64'(d), 64'(stamp(40)[63:32]));
      chk(irq == 1'b0, "R8 irq drops after high read", 64'(irq), 0);
      tx_irq_en = 1'b0;
      time_now = stamp(42); tx_evt = 1'b1;
      @(negedge clk);
      tx_evt = 1'b0;
      chk(irq == 1'b0, "R8 masked irq", 64'(irq), 0);
      rd(4'd0, d);
      chk(d[9:8] == 2'b01, "R7 busy without overflow", 64'(d[9:8]), 1);
      rd(4'd2, d);
      chk(d == stamp(42)[63:32], "R7 new capture after free", 64'(d), 64'(stamp(42)[63:32]));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_fill;
      t_full_drop;
      t_collide;
      t_drain;
      t_tx;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule